// File: doc/BRIEF.md
# Scatter-Gather DMA Engine with Completion Flag

This block is a bus-mastering DMA engine that moves 32-bit words between a storage device port and system memory. Software places a list of descriptors in memory, loads the list pointer and a completion-area address into the register file, and sets the start bit. The engine then walks the list. For each descriptor it reads the buffer address and the byte length, and moves that many bytes in the direction held in the control word. After the last descriptor it writes a block of all-ones words into the completion area. Software polls that area to learn that every data write has landed, even when register reads and memory writes are not ordered with respect to each other. A stop bit requests a halt and acts as a handshake: it stays visible until the engine is idle. A failed memory response halts the engine and raises a sticky error bit.

The control state machine has nine states. `ST_IDLE` leaves on a start command and goes to `ST_FETCH_ADDR`. `ST_FETCH_ADDR` reads descriptor word 1 and goes to `ST_FETCH_LEN` when the response arrives. `ST_FETCH_LEN` reads descriptor word 3 and goes to `ST_SEG_CHECK`. `ST_SEG_CHECK` goes to `ST_IDLE` on a pending stop. When the segment is used up, it goes to `ST_FLAG_WR` after the end-of-list descriptor and to `ST_FETCH_ADDR` (next descriptor) otherwise. Otherwise it goes to `ST_DEV_TAKE` (device to memory) or `ST_MEM_RD` (memory to device). `ST_DEV_TAKE` accepts a device word and goes to `ST_MEM_WR`, or goes to `ST_IDLE` on stop. `ST_MEM_WR` returns to `ST_SEG_CHECK`. `ST_MEM_RD` goes to `ST_DEV_GIVE`. `ST_DEV_GIVE` returns to `ST_SEG_CHECK` once the device takes the word. `ST_FLAG_WR` loops until the last completion word is written, then goes to `ST_IDLE`. Any memory error response sends every requesting state to `ST_IDLE`.

Top module: `sgdma_engine_top`

## Requirements
- R1: After reset every register reads zero: control/status, byte counters, current address, pointers, timing and completion address.
- R2: Registers are 32 bits at byte offset = 4 × word index. The word indices are timing 0, list pointer low 1, list pointer high 2, current address low 3, current address high 4, device byte count 5, memory byte count 6, control/status 7 and completion address 8. Indices 0, 1, 2 and 8 read back what was written. Control/status bits are start 0, stop 1, direction 2, active 3 and error 4.
- R3: Writing the control word with start=1 and stop=0 while idle launches a transfer from the loaded list pointer. Active reads 1 from the cycle after the write until the engine returns to idle. Start always reads 0.
- R4: A descriptor is 16 bytes and each word is stored byte-reversed (big-endian). Word 1 is the buffer byte address. Word 3 holds the byte length in bits 15:0 (a multiple of 4) and end-of-list in bit 31. Descriptors are consecutive in memory. A zero-length descriptor moves no data.
- R5: Direction 1 moves device words into memory. Direction 0 moves memory words out to the device. Word order is kept within and across descriptors.
- R6: After the end-of-list descriptor completes, the engine writes 32 words of 0xFFFFFFFF (128 bytes) starting at the completion address and writes nothing past that area. Active then drops.
- R7: Start clears both byte counters. After a clean transfer both counters equal the total byte length. Current address low reads the address after the last word moved, and current address high reads 0.
- R8: A control write with stop=1 while active makes stop read 1 until the engine is idle, after which it reads 0. A stopped transfer writes no completion area. A stop written while idle has no effect.
- R9: A start written while active is ignored. The direction bit keeps its value and the transfer continues.
- R10: A memory error response halts the engine, sets error and clears active. No completion area is written. For a device-to-memory transfer the device count then exceeds the memory count by 4.
- R11: Error stays set until a configuration write clears it. A configuration write is a control write with start=0 and stop=0 while idle. A stop write does not clear it.
- R12: Only one memory request is outstanding at a time. Address, write-enable and write data hold steady from the request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address (word index in bits 5:2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response for the pending request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rdata | input | 32 | Memory read data |
| dev_rx_valid | input | 1 | Device offers a word (device to memory) |
| dev_rx_data | input | 32 | Device word |
| dev_rx_ready | output | 1 | Engine accepts the device word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_data | output | 32 | Word for the device |
| dev_tx_ready | input | 1 | Device accepts the word |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only while `mem_req` is high and answers each request exactly once. They also assume that software writes a start only after the list and the completion address are in place. The bench memory model answers a request on the falling edge after it sees it, then drops the response for a cycle, so each request gets a single response. All register and device stimulus is driven on falling edges and sampled away from the rising edge. Descriptor lengths are kept to multiples of four bytes, and addresses stay inside the modelled 4 KiB.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int REG_AW = 6;

    localparam logic [3:0] RIX_TIMING  = 4'd0;
    localparam logic [3:0] RIX_PTR_LO  = 4'd1;
    localparam logic [3:0] RIX_PTR_HI  = 4'd2;
    localparam logic [3:0] RIX_CUR_LO  = 4'd3;
    localparam logic [3:0] RIX_CUR_HI  = 4'd4;
    localparam logic [3:0] RIX_DEV_CNT = 4'd5;
    localparam logic [3:0] RIX_MEM_CNT = 4'd6;
    localparam logic [3:0] RIX_CTRL    = 4'd7;
    localparam logic [3:0] RIX_COMP    = 4'd8;

    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_ACTIVE = 3;
    localparam int CB_ERR    = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_FETCH_LEN,
        ST_SEG_CHECK,
        ST_DEV_TAKE,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_DEV_GIVE,
        ST_FLAG_WR
    } eng_state_e;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                eng_busy,
    input  logic                eng_err,
    input  logic [31:0]         cur_addr,
    input  logic [31:0]         dev_cnt,
    input  logic [31:0]         mem_cnt,
    output logic                start_go,
    output logic                dir,
    output logic                stop_req,
    output logic [31:0]         list_ptr,
    output logic [31:0]         comp_addr
);

    logic [3:0]  widx;
    logic        ctrl_wr;
    logic        cfg_wr;
    logic [31:0] timing_q;
    logic [31:0] ptr_lo_q;
    logic [31:0] ptr_hi_q;
    logic [31:0] comp_q;
    logic        dir_q;
    logic        err_q;
    logic        stop_q;
    logic        unused_addr_bits;

    assign widx             = reg_addr[REG_AW-1:2];
    assign unused_addr_bits = ^reg_addr[1:0];
    assign ctrl_wr          = reg_we && (widx == RIX_CTRL);
    assign start_go = ctrl_wr && reg_wdata[CB_START] && !reg_wdata[CB_STOP] && !eng_busy;
    assign cfg_wr   = ctrl_wr && !reg_wdata[CB_START] && !reg_wdata[CB_STOP] && !eng_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= '0;
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
            comp_q   <= '0;
        end else if (reg_we) begin
            if (widx == RIX_TIMING) timing_q <= reg_wdata;
            if (widx == RIX_PTR_LO) ptr_lo_q <= reg_wdata;
            if (widx == RIX_PTR_HI) ptr_hi_q <= reg_wdata;
            if (widx == RIX_COMP)   comp_q   <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (start_go || cfg_wr)
                dir_q <= reg_wdata[CB_DIR];
            if (eng_err)
                err_q <= 1'b1;
            else if (cfg_wr)
                err_q <= 1'b0;
            if (!eng_busy)
                stop_q <= 1'b0;
            else if (ctrl_wr && reg_wdata[CB_STOP])
                stop_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (widx)
            RIX_TIMING:  reg_rdata = timing_q;
            RIX_PTR_LO:  reg_rdata = ptr_lo_q;
            RIX_PTR_HI:  reg_rdata = ptr_hi_q;
            RIX_CUR_LO:  reg_rdata = cur_addr;
            RIX_CUR_HI:  reg_rdata = '0;
            RIX_DEV_CNT: reg_rdata = dev_cnt;
            RIX_MEM_CNT: reg_rdata = mem_cnt;
            RIX_CTRL: begin
                reg_rdata[CB_STOP]   = stop_q;
                reg_rdata[CB_DIR]    = dir_q;
                reg_rdata[CB_ACTIVE] = eng_busy;
                reg_rdata[CB_ERR]    = err_q;
            end
            RIX_COMP:    reg_rdata = comp_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign dir       = dir_q;
    assign stop_req  = stop_q;
    assign list_ptr  = ptr_lo_q;
    assign comp_addr = comp_q;

    // R8: the stop handshake bit falls once the engine has been idle
    a_r8_stop_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |=> !stop_q);

    // R9: direction cannot move while a transfer is running
    a_r9_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(dir_q));

    // R11: error is sticky apart from a configuration write
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(ctrl_wr && !eng_busy && !reg_wdata[CB_START] && !reg_wdata[CB_STOP]))
        |=> err_q);

endmodule

// File: rtl/sgdma_core.sv
module sgdma_core
    import sgdma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FLAG_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_go,
    input  logic        dir,
    input  logic        stop_req,
    input  logic [31:0] list_ptr,
    input  logic [31:0] comp_addr,
    output logic        busy,
    output logic        err_pulse,
    output logic [31:0] cur_addr,
    output logic [31:0] dev_cnt,
    output logic [31:0] mem_cnt,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rsp_valid,
    input  logic        mem_rsp_err,
    input  logic [31:0] mem_rdata,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready
);

    localparam int FLAG_WORDS = FLAG_BYTES / 4;
    localparam int FW         = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1;
    localparam int WC_W       = LEN_W - 2;

    eng_state_e        state_q, state_d;
    logic [31:0]       desc_q;
    logic [31:0]       addr_q;
    logic [WC_W-1:0]   words_q;
    logic              eol_q;
    logic [31:0]       data_q;
    logic [FW-1:0]     flag_q;
    logic [31:0]       dev_cnt_q;
    logic [31:0]       mem_cnt_q;
    logic [31:0]       rsp_sw;
    logic              rsp_ok;
    logic              rsp_bad;
    logic              flag_last;
    logic              seg_empty;
    logic              unused_len_bits;

    assign rsp_sw          = swap32(mem_rdata);
    assign rsp_ok          = mem_rsp_valid && !mem_rsp_err;
    assign rsp_bad         = mem_rsp_valid && mem_rsp_err;
    assign flag_last       = (flag_q == FW'(FLAG_WORDS - 1));
    assign seg_empty       = (words_q == '0);
    assign unused_len_bits = ^{rsp_sw[30:LEN_W], rsp_sw[1:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_go) state_d = ST_FETCH_ADDR;
            ST_FETCH_ADDR: if (rsp_bad) state_d = ST_IDLE;
                           else if (rsp_ok) state_d = ST_FETCH_LEN;
            ST_FETCH_LEN:  if (rsp_bad) state_d = ST_IDLE;
                           else if (rsp_ok) state_d = ST_SEG_CHECK;
            ST_SEG_CHECK: begin
                if (stop_req)        state_d = ST_IDLE;
                else if (seg_empty)  state_d = eol_q ? ST_FLAG_WR : ST_FETCH_ADDR;
                else                 state_d = dir ? ST_DEV_TAKE : ST_MEM_RD;
            end
            ST_DEV_TAKE:   if (stop_req) state_d = ST_IDLE;
                           else if (dev_rx_valid) state_d = ST_MEM_WR;
            ST_MEM_WR:     if (rsp_bad) state_d = ST_IDLE;
                           else if (rsp_ok) state_d = ST_SEG_CHECK;
            ST_MEM_RD:     if (rsp_bad) state_d = ST_IDLE;
                           else if (rsp_ok) state_d = ST_DEV_GIVE;
            ST_DEV_GIVE:   if (dev_tx_ready) state_d = ST_SEG_CHECK;
            ST_FLAG_WR:    if (rsp_bad) state_d = ST_IDLE;
                           else if (rsp_ok && flag_last) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // datapath registers advanced by the state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q    <= '0;
            addr_q    <= '0;
            words_q   <= '0;
            eol_q     <= 1'b0;
            data_q    <= '0;
            flag_q    <= '0;
            dev_cnt_q <= '0;
            mem_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_go) begin
                    desc_q    <= list_ptr;
                    dev_cnt_q <= '0;
                    mem_cnt_q <= '0;
                    flag_q    <= '0;
                end
                ST_FETCH_ADDR: if (rsp_ok) addr_q <= rsp_sw;
                ST_FETCH_LEN: if (rsp_ok) begin
                    words_q <= rsp_sw[LEN_W-1:2];
                    eol_q   <= rsp_sw[31];
                end
                ST_SEG_CHECK: if (!stop_req && seg_empty && !eol_q)
                    desc_q <= desc_q + 32'd16;
                ST_DEV_TAKE: if (!stop_req && dev_rx_valid) begin
                    data_q    <= dev_rx_data;
                    dev_cnt_q <= dev_cnt_q + 32'd4;
                end
                ST_MEM_WR: if (rsp_ok) begin
                    mem_cnt_q <= mem_cnt_q + 32'd4;
                    addr_q    <= addr_q + 32'd4;
                    words_q   <= words_q - 1'b1;
                end
                ST_MEM_RD: if (rsp_ok) begin
                    data_q    <= mem_rdata;
                    mem_cnt_q <= mem_cnt_q + 32'd4;
                    addr_q    <= addr_q + 32'd4;
                end
                ST_DEV_GIVE: if (dev_tx_ready) begin
                    dev_cnt_q <= dev_cnt_q + 32'd4;
                    words_q   <= words_q - 1'b1;
                end
                ST_FLAG_WR: if (rsp_ok) flag_q <= flag_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        dev_rx_ready = 1'b0;
        dev_tx_valid = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + 32'd4;
            end
            ST_FETCH_LEN: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + 32'd12;
            end
            ST_DEV_TAKE: dev_rx_ready = !stop_req;
            ST_MEM_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_q;
                mem_wdata = data_q;
            end
            ST_MEM_RD: begin
                mem_req  = 1'b1;
                mem_addr = addr_q;
            end
            ST_DEV_GIVE: dev_tx_valid = 1'b1;
            ST_FLAG_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = comp_addr + {{(30-FW){1'b0}}, flag_q, 2'b00};
                mem_wdata = '1;
            end
            default: ;
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign err_pulse   = mem_req && rsp_bad;
    assign cur_addr    = addr_q;
    assign dev_cnt     = dev_cnt_q;
    assign mem_cnt     = mem_cnt_q;
    assign dev_tx_data = data_q;

    // R12: a pending request does not move until answered
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: an error response leaves the engine idle
    a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rsp_bad) |=> !busy);

    // R3: nothing moves on any port while idle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !dev_rx_ready && !dev_tx_valid));

    // R5: the two device directions are never offered together
    a_r5_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rx_ready && dev_tx_valid));

    // R7: an accepted memory write advances the memory counter by one word
    a_r7_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM_WR && rsp_ok) |=> (mem_cnt_q == $past(mem_cnt_q) + 32'd4));

endmodule

// File: rtl/sgdma_engine_top.sv
module sgdma_engine_top
    import sgdma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FLAG_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rsp_valid,
    input  logic        mem_rsp_err,
    input  logic [31:0] mem_rdata,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready
);

    logic        busy;
    logic        err_pulse;
    logic        start_go;
    logic        dir;
    logic        stop_req;
    logic [31:0] list_ptr;
    logic [31:0] comp_addr;
    logic [31:0] cur_addr;
    logic [31:0] dev_cnt;
    logic [31:0] mem_cnt;

    sgdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_busy  (busy),
        .eng_err   (err_pulse),
        .cur_addr  (cur_addr),
        .dev_cnt   (dev_cnt),
        .mem_cnt   (mem_cnt),
        .start_go  (start_go),
        .dir       (dir),
        .stop_req  (stop_req),
        .list_ptr  (list_ptr),
        .comp_addr (comp_addr)
    );

    sgdma_core #(
        .LEN_W      (LEN_W),
        .FLAG_BYTES (FLAG_BYTES)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_go      (start_go),
        .dir           (dir),
        .stop_req      (stop_req),
        .list_ptr      (list_ptr),
        .comp_addr     (comp_addr),
        .busy          (busy),
        .err_pulse     (err_pulse),
        .cur_addr      (cur_addr),
        .dev_cnt       (dev_cnt),
        .mem_cnt       (mem_cnt),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .mem_rdata     (mem_rdata),
        .dev_rx_valid  (dev_rx_valid),
        .dev_rx_data   (dev_rx_data),
        .dev_rx_ready  (dev_rx_ready),
        .dev_tx_valid  (dev_tx_valid),
        .dev_tx_data   (dev_tx_data),
        .dev_tx_ready  (dev_tx_ready)
    );

endmodule

// File: tb/sgdma_engine_top_tb_top.sv
module sgdma_engine_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] LIST_AT = 32'h100;
    localparam logic [31:0] BUF_AT  = 32'h400;
    localparam logic [31:0] BUF_GAP = 32'h200;
    localparam logic [31:0] COMP_AT = 32'hC00;

    typedef struct packed {
        logic        dir;
        logic [1:0]  nseg;
        logic [15:0] l0;
        logic [15:0] l1;
        logic [15:0] l2;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 2'd1, 16'd16, 16'd0,  16'd0},
        '{1'b0, 2'd2, 16'd8,  16'd24, 16'd0},
        '{1'b1, 2'd3, 16'd12, 16'd0,  16'd20},
        '{1'b0, 2'd3, 16'd4,  16'd32, 16'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dev_rx_valid = 1'b0;
    logic [31:0] dev_rx_data = '0;
    logic        dev_rx_ready;
    logic        dev_tx_valid;
    logic [31:0] dev_tx_data;
    logic        dev_tx_ready = 1'b0;

    logic [31:0] mem [1024];
    logic [31:0] cap [256];
    int          cap_n = 0;
    int          rx_idx = 0;
    logic        rx_pend = 1'b0;
    logic        rx_en = 1'b0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgdma_engine_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready)
    );

    // memory model: answers a seen request on the next falling edge, once
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end else if (mem_req) begin
            mem_rsp_valid = 1'b1;
            if (err_on && mem_addr == err_addr)
                mem_rsp_err = 1'b1;
            else if (mem_we)
                mem[mem_addr[11:2]] = mem_wdata;
            else
                mem_rdata = mem[mem_addr[11:2]];
        end
    end

    // device model: word source and word sink
    always @(negedge clk) begin
        if (rx_pend) rx_idx++;
        dev_rx_valid = rx_en;
        dev_rx_data  = 32'hA500_0000 + rx_idx;
        rx_pend      = dev_rx_valid && dev_rx_ready;
        if (dev_tx_valid && dev_tx_ready) begin
            cap[cap_n] = dev_tx_data;
            cap_n++;
        end
    end

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = {idx, 2'b00};
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] idx, output logic [31:0] d);
        reg_addr = {idx, 2'b00};
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            reg_rd(4'd7, v);
            if (!v[3]) return;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        cap_n  = 0;
        rx_idx = 0;
    endtask

    task automatic put_desc(input int k, input logic [31:0] a,
                            input logic [15:0] len, input logic eol);
        mem[(LIST_AT + 16*k + 4)  >> 2] = bsw(a);
        mem[(LIST_AT + 16*k + 12) >> 2] = bsw({eol, 15'd0, len});
    endtask

    task automatic run_vec(input int vi);
        vec_t        v;
        logic [15:0] lens [3];
        logic [31:0] rd;
        logic [31:0] last_end;
        int          tot;
        int          run;
        int          miss;
        int          flag_bad;
        v = VECS[vi];
        lens[0] = v.l0; lens[1] = v.l1; lens[2] = v.l2;
        clear_mem();
        tot = 0;
        last_end = '0;
        for (int k = 0; k < int'(v.nseg); k++) begin
            put_desc(k, BUF_AT + BUF_GAP*k, lens[k], k == int'(v.nseg) - 1);
            tot += int'(lens[k]);
            if (lens[k] != 0) last_end = BUF_AT + BUF_GAP*k + {16'd0, lens[k]};
            if (!v.dir)
                for (int j = 0; j < int'(lens[k]) / 4; j++)
                    mem[((BUF_AT + BUF_GAP*k) >> 2) + j] = 32'h3C00_0000 + (k << 8) + j;
        end
        rx_en        = 1'b1;
        dev_tx_ready = 1'b1;
        reg_wr(4'd1, LIST_AT);
        reg_wr(4'd8, COMP_AT);
        reg_wr(4'd7, {29'd0, v.dir, 2'b00});
        reg_wr(4'd7, {29'd0, v.dir, 2'b01});
        wait_idle();
        reg_rd(4'd7, rd);
        check("R3", $sformatf("vec%0d ctrl after run", vi), rd, {29'd0, v.dir, 2'b00});
        reg_rd(4'd5, rd);
        check("R7", $sformatf("vec%0d device count", vi), rd, tot);
        reg_rd(4'd6, rd);
        check("R7", $sformatf("vec%0d memory count", vi), rd, tot);
        reg_rd(4'd3, rd);
        check("R7", $sformatf("vec%0d current address", vi), rd, last_end);
        miss = 0;
        run  = 0;
        for (int k = 0; k < int'(v.nseg); k++)
            for (int j = 0; j < int'(lens[k]) / 4; j++) begin
                if (v.dir) begin
                    if (mem[((BUF_AT + BUF_GAP*k) >> 2) + j] !== 32'hA500_0000 + run) miss++;
                end else begin
                    if (cap[run] !== 32'h3C00_0000 + (k << 8) + j) miss++;
                end
                run++;
            end
        if (!v.dir) check("R5", $sformatf("vec%0d words sent", vi), cap_n, tot / 4);
        check("R4", $sformatf("vec%0d data mismatches (R5)", vi), miss, 0);
        flag_bad = 0;
        for (int i = 0; i < 32; i++) if (mem[(COMP_AT >> 2) + i] !== 32'hFFFF_FFFF) flag_bad++;
        check("R6", $sformatf("vec%0d completion words not set", vi), flag_bad, 0);
        check("R6", $sformatf("vec%0d word past completion area", vi), mem[(COMP_AT >> 2) + 32], 0);
        rx_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 9; i++) begin
            reg_rd(i[3:0], rd);
            check("R1", $sformatf("reg %0d after reset", i), rd, 0);
        end

        // R2: read-back of plain registers
        reg_wr(4'd0, 32'h1234_5678);
        reg_wr(4'd2, 32'hDEAD_0001);
        reg_wr(4'd8, 32'h0000_0C40);
        reg_rd(4'd0, rd); check("R2", "timing read-back", rd, 32'h1234_5678);
        reg_rd(4'd2, rd); check("R2", "pointer high read-back", rd, 32'hDEAD_0001);
        reg_rd(4'd8, rd); check("R2", "completion address read-back", rd, 32'h0000_0C40);
        reg_rd(4'd4, rd); check("R7", "current address high", rd, 0);

        // vector table: R4 R5 R6 R7
        for (int vi = 0; vi < 4; vi++) run_vec(vi);

        // R9 and R8: ignored restart, then stop handshake with a stalled device
        clear_mem();
        put_desc(0, BUF_AT, 16'd16, 1'b1);
        rx_en = 1'b0;
        reg_wr(4'd1, LIST_AT);
        reg_wr(4'd8, COMP_AT);
        reg_wr(4'd7, 32'h5);
        repeat (10) @(negedge clk);
        reg_rd(4'd7, rd); check("R3", "active while stalled", rd, 32'h0C);
        reg_wr(4'd7, 32'h1);
        reg_rd(4'd7, rd); check("R9", "start while active ignored", rd, 32'h0C);
        reg_wr(4'd7, 32'h2);
        reg_rd(4'd7, rd); check("R8", "stop visible while active", rd, 32'h0E);
        repeat (3) @(negedge clk);
        reg_rd(4'd7, rd); check("R8", "stop cleared once idle", rd, 32'h04);
        check("R8", "no completion after stop", mem[COMP_AT >> 2], 0);
        reg_rd(4'd6, rd); check("R8", "no memory words after stop", rd, 0);

        // R8: stop while idle has no effect
        reg_wr(4'd7, 32'h2);
        reg_rd(4'd7, rd); check("R8", "stop while idle ignored", rd, 32'h04);

        // R10 and R11: memory error on the second data write
        clear_mem();
        put_desc(0, BUF_AT, 16'd16, 1'b1);
        err_on   = 1'b1;
        err_addr = BUF_AT + 32'd4;
        rx_en    = 1'b1;
        reg_wr(4'd7, 32'h4);
        reg_wr(4'd7, 32'h5);
        wait_idle();
        rx_en = 1'b0;
        err_on = 1'b0;
        reg_rd(4'd7, rd); check("R10", "error set, active clear", rd, 32'h14);
        reg_rd(4'd5, rd); check("R10", "device count", rd, 32'd8);
        reg_rd(4'd6, rd); check("R10", "memory count", rd, 32'd4);
        check("R10", "no completion after error", mem[COMP_AT >> 2], 0);
        reg_wr(4'd7, 32'h2);
        reg_rd(4'd7, rd); check("R11", "stop write keeps error", rd, 32'h14);
        reg_wr(4'd7, 32'h4);
        reg_rd(4'd7, rd); check("R11", "configuration write clears error", rd, 32'h04);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule